// File: doc/BRIEF.md
# UART Flag and Interrupt Request Controller

This block holds the ten status flags of a UART and turns them into three interrupt request lines: one for the transmitter, one for receiver events and one for error conditions. The transmit and receive datapaths send it single-cycle event strobes. A register interface sends it a write strobe for the transmit data register, one enable bit for each flag, and a write-one-to-clear strobe vector. The flags can always be read for polling. A flag's enable only decides whether that flag may drive its request line.

The transmit side tracks two conditions. The first is buffer room, which is set when the datapath moves a character out of the holding buffer. The second is transmission complete. That flag is raised only after the datapath reports that the final stop bit or break has left the shifter, and then a programmable number of bit times of idle line have passed. A data register write clears both transmit flags, and it abandons any completion wait that is in progress. Receive and error flags are sticky. Each request line is a registered OR of its enabled flags, so the line is a free-of-glitches level that follows the flags.

Top module: `uart_flag_irq_ctrl`

## Requirements
- R1: During reset and on the first edge after it, `flags` reads 10'b00_0000_0011 (buffer room and transmission complete set, all others clear), and all three request lines are low while reset is held.
- R2: The flag layout is: bit 0 buffer room, bit 1 transmission complete, bits 2..5 receive events equal to `rx_evt[0..3]` (character received, idle line, line edge, break detected), and bits 6..9 error events equal to `err_evt[0..3]` (overrun, noise, framing, parity).
- R3: Bit 0 sets on the edge after `tx_room_evt` and clears on the edge after `tx_data_wr`. When both arrive together, the set wins. Bit 0 never falls without a data write.
- R4: Bit 1 clears on the edge after `tx_data_wr`. After a `tx_shift_done` strobe, bit 1 sets on the edge of the TC_DELAY_TICKS-th later `bit_tick`. A new `tx_shift_done` restarts this count, and bit 1 rises only in a cycle that carries `bit_tick`.
- R5: Bits 2..9 are sticky. Each one sets on the edge after its event. It clears on the edge after a 1 in the matching bit of `flag_clr`. An event in the same cycle as a clear leaves the flag set.
- R6: The bits of `flag_clr` at positions 0 and 1 have no effect on the transmit flags.
- R7: The enable bits `flag_en` never change the flags. A flag whose enable is 0 still sets and can be read.
- R8: On the same edge as the flags update, `irq_tx` becomes the OR of bits 1..0, `irq_rx` the OR of bits 5..2 and `irq_err` the OR of bits 9..6, each flag ANDed with its `flag_en` bit.
- R9: While buffer room is set and its enable is 1, `irq_tx` stays high as a level for every cycle, not as a pulse.
- R10: A `tx_data_wr` that arrives during a completion wait cancels the wait, so bit 1 stays clear until a later `tx_shift_done` completes its wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_room_evt | input | 1 | Holding buffer emptied into the shifter |
| tx_data_wr | input | 1 | Transmit data register written |
| tx_shift_done | input | 1 | Last stop bit or break finished shifting |
| bit_tick | input | 1 | One pulse per bit time |
| rx_evt | input | 4 | Receive event strobes (received, idle, edge, break) |
| err_evt | input | 4 | Error event strobes (overrun, noise, framing, parity) |
| flag_en | input | 10 | Per-flag request enables |
| flag_clr | input | 10 | Write-one-to-clear strobes |
| flags | output | 10 | Flag bits for polling |
| irq_tx | output | 1 | Transmit request |
| irq_rx | output | 1 | Receive request |
| irq_err | output | 1 | Error request |

## Verification
Every flag and every request line is due exactly one clock edge after the strobe or enable change that moves it. The completion flag is the one exception, and it is due on the edge of the TC_DELAY_TICKS-th qualifying bit tick. The bench changes its inputs at the falling edge and computes the next flag and request state in a model function. It compares the outputs at the following falling edge, which is one rising edge later. Directed sequences put the set/clear collisions and the wait cancellation on exact cycles. The random phase covers the remaining combinations.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int N_TX  = 2;
   localparam int N_RX  = 4;
   localparam int N_ERR = 4;
   localparam int N_SRC = N_TX + N_RX + N_ERR;

   localparam int IDX_ROOM = 0;
   localparam int IDX_DONE = 1;
   localparam int RX_LO    = N_TX;
   localparam int RX_HI    = N_TX + N_RX - 1;
   localparam int ERR_LO   = N_TX + N_RX;
   localparam int ERR_HI   = N_SRC - 1;

   typedef logic [N_SRC-1:0] flag_vec_t;
endpackage

// File: rtl/uart_sticky_flags.sv
module uart_sticky_flags #(
   parameter int          W        = 1,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] d_o,
   output logic [W-1:0] q_o
);
   initial begin
      if (W < 1) $error("uart_sticky_flags: W must be at least 1");
   end

   generate
      if (SET_WINS) begin : g_set_wins
         assign d_o = set_i | (q_o & ~clr_i);
      end else begin : g_clr_wins
         assign d_o = (q_o | set_i) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= d_o;
   end
endmodule

// File: rtl/uart_txc_timer.sv
module uart_txc_timer #(
   parameter int DELAY_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_done_i,
   input  logic data_wr_i,
   input  logic bit_tick_i,
   output logic set_o
);
   localparam int CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);
   assign set_o   = armed_q && bit_tick_i && at_last && !data_wr_i && !shift_done_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (data_wr_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (shift_done_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && bit_tick_i) begin
         if (at_last) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_irq_group.sv
module uart_irq_group #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flag_d_i,
   input  logic [W-1:0] en_i,
   output logic         req_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) req_o <= 1'b0;
      else        req_o <= |(flag_d_i & en_i);
   end
endmodule

// File: rtl/uart_flag_irq_ctrl.sv
module uart_flag_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int TC_DELAY_TICKS = 1,
   parameter bit SET_WINS       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_room_evt,
   input  logic             tx_data_wr,
   input  logic             tx_shift_done,
   input  logic             bit_tick,
   input  logic [N_RX-1:0]  rx_evt,
   input  logic [N_ERR-1:0] err_evt,
   input  logic [N_SRC-1:0] flag_en,
   input  logic [N_SRC-1:0] flag_clr,
   output logic [N_SRC-1:0] flags,
   output logic             irq_tx,
   output logic             irq_rx,
   output logic             irq_err
);
   localparam int N_STICKY = N_RX + N_ERR;

   initial begin
      if (TC_DELAY_TICKS < 1) $error("uart_flag_irq_ctrl: TC_DELAY_TICKS must be >= 1");
      if (N_SRC != 10)        $error("uart_flag_irq_ctrl: source count mismatch");
   end

   flag_vec_t flag_d;
   logic      done_set;

   uart_sticky_flags #(.W(1), .RST_VAL(1'b1), .SET_WINS(1'b1)) u_room (
      .clk(clk), .rst_n(rst_n),
      .set_i(tx_room_evt), .clr_i(tx_data_wr),
      .d_o(flag_d[IDX_ROOM]), .q_o(flags[IDX_ROOM])
   );

   uart_txc_timer #(.DELAY_TICKS(TC_DELAY_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .shift_done_i(tx_shift_done), .data_wr_i(tx_data_wr),
      .bit_tick_i(bit_tick), .set_o(done_set)
   );

   uart_sticky_flags #(.W(1), .RST_VAL(1'b1), .SET_WINS(1'b1)) u_done (
      .clk(clk), .rst_n(rst_n),
      .set_i(done_set), .clr_i(tx_data_wr),
      .d_o(flag_d[IDX_DONE]), .q_o(flags[IDX_DONE])
   );

   uart_sticky_flags #(.W(N_STICKY), .RST_VAL('0), .SET_WINS(SET_WINS)) u_sticky (
      .clk(clk), .rst_n(rst_n),
      .set_i({err_evt, rx_evt}), .clr_i(flag_clr[ERR_HI:RX_LO]),
      .d_o(flag_d[ERR_HI:RX_LO]), .q_o(flags[ERR_HI:RX_LO])
   );

   uart_irq_group #(.W(N_TX)) u_grp_tx (
      .clk(clk), .rst_n(rst_n),
      .flag_d_i(flag_d[N_TX-1:0]), .en_i(flag_en[N_TX-1:0]), .req_o(irq_tx)
   );
   uart_irq_group #(.W(N_RX)) u_grp_rx (
      .clk(clk), .rst_n(rst_n),
      .flag_d_i(flag_d[RX_HI:RX_LO]), .en_i(flag_en[RX_HI:RX_LO]), .req_o(irq_rx)
   );
   uart_irq_group #(.W(N_ERR)) u_grp_err (
      .clk(clk), .rst_n(rst_n),
      .flag_d_i(flag_d[ERR_HI:ERR_LO]), .en_i(flag_en[ERR_HI:ERR_LO]), .req_o(irq_err)
   );

   logic unused_clr;
   assign unused_clr = ^flag_clr[N_TX-1:0];
endmodule

// File: rtl/uart_flag_irq_ctrl_chk.sv
module uart_flag_irq_ctrl_chk
   import uart_irq_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_room_evt,
   input logic             tx_data_wr,
   input logic             bit_tick,
   input logic [N_RX-1:0]  rx_evt,
   input logic [N_ERR-1:0] err_evt,
   input logic [N_SRC-1:0] flag_en,
   input logic [N_SRC-1:0] flag_clr,
   input logic [N_SRC-1:0] flags,
   input logic             irq_tx,
   input logic             irq_rx,
   input logic             irq_err
);
   logic [N_RX+N_ERR-1:0] evt;
   assign evt = {err_evt, rx_evt};

   p_room_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_data_wr |=> (flags[IDX_ROOM] || !$past(flags[IDX_ROOM])));

   p_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_wr && !tx_room_evt) |=> (!flags[IDX_ROOM] && !flags[IDX_DONE]));

   p_done_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[IDX_DONE]) |-> $past(bit_tick));

   p_irq_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_tx == |(flags[RX_LO-1:0] & $past(flag_en[RX_LO-1:0]))));

   p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_rx == |(flags[RX_HI:RX_LO] & $past(flag_en[RX_HI:RX_LO]))));

   p_irq_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_err == |(flags[ERR_HI:ERR_LO] & $past(flag_en[ERR_HI:ERR_LO]))));

   genvar gi;
   generate
      for (gi = 0; gi < N_RX + N_ERR; gi++) begin : g_sticky
         if (SET_WINS) begin : g_sw
            p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
               evt[gi] |=> flags[RX_LO+gi]);
         end else begin : g_cw
            p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (evt[gi] && !flag_clr[RX_LO+gi]) |=> flags[RX_LO+gi]);
         end
         p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[RX_LO+gi] && !evt[gi]) |=> !flags[RX_LO+gi]);
         p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_clr[RX_LO+gi] && !evt[gi]) |=> (flags[RX_LO+gi] == $past(flags[RX_LO+gi])));
      end
   endgenerate
endmodule

bind uart_flag_irq_ctrl uart_flag_irq_ctrl_chk #(.SET_WINS(SET_WINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_room_evt(tx_room_evt), .tx_data_wr(tx_data_wr),
   .bit_tick(bit_tick), .rx_evt(rx_evt), .err_evt(err_evt), .flag_en(flag_en),
   .flag_clr(flag_clr), .flags(flags), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/uart_flag_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_flag_irq_ctrl_tb;
   localparam int D = 1;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_room_evt, tx_data_wr, tx_shift_done, bit_tick;
   logic [3:0] rx_evt, err_evt;
   logic [9:0] flag_en, flag_clr;
   logic [9:0] flags;
   logic       irq_tx, irq_rx, irq_err;

   int n_chk  = 0;
   int n_fail = 0;

   logic [9:0] mf;
   logic [2:0] mirq;
   logic       m_armed;
   int         m_cnt;

   always #2.5 clk = ~clk;

   uart_flag_irq_ctrl #(.TC_DELAY_TICKS(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_room_evt(tx_room_evt), .tx_data_wr(tx_data_wr),
      .tx_shift_done(tx_shift_done), .bit_tick(bit_tick), .rx_evt(rx_evt),
      .err_evt(err_evt), .flag_en(flag_en), .flag_clr(flag_clr), .flags(flags),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic quiet();
      tx_room_evt = 0; tx_data_wr = 0; tx_shift_done = 0; bit_tick = 0;
      rx_evt = '0; err_evt = '0; flag_clr = '0;
   endtask

   // Next-state model built from R3, R4, R5, R8, R10
   function automatic void model_step();
      logic [9:0] nf;
      logic       set_c;
      nf    = mf;
      set_c = 1'b0;
      if (tx_data_wr) m_armed = 1'b0;
      else if (tx_shift_done) begin m_armed = 1'b1; m_cnt = 0; end
      else if (m_armed && bit_tick) begin
         if (m_cnt == D - 1) begin set_c = 1'b1; m_armed = 1'b0; end
         else m_cnt++;
      end
      nf[0] = tx_room_evt ? 1'b1 : (tx_data_wr ? 1'b0 : mf[0]);
      nf[1] = set_c       ? 1'b1 : (tx_data_wr ? 1'b0 : mf[1]);
      for (int i = 0; i < 8; i++)
         nf[2+i] = ({err_evt, rx_evt} >> i) & 1 ? 1'b1 : (flag_clr[2+i] ? 1'b0 : mf[2+i]);
      mirq = {|(nf[9:6] & flag_en[9:6]), |(nf[5:2] & flag_en[5:2]), |(nf[1:0] & flag_en[1:0])};
      mf = nf;
   endfunction

   task automatic cycle();
      model_step();
      @(negedge clk);
      chk("R3 room flag", flags[0], mf[0]);
      chk("R4 done flag", flags[1], mf[1]);
      chk("R5 sticky flags", flags[9:2], mf[9:2]);
      chk("R8 requests", {irq_err, irq_rx, irq_tx}, mirq);
      quiet();
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 0; quiet(); flag_en = '1;
      mf = 10'b11; mirq = '0; m_armed = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset flags", flags, 10'b00_0000_0011);
      chk("R1 reset requests", {irq_err, irq_rx, irq_tx}, 3'b000);
      rst_n = 1;

      // R1/R8: first edge after reset
      flag_en = '0; cycle();
      chk("R1 flags after reset", flags, 10'b00_0000_0011);

      // R2 layout and R7 enables do not mask flags
      rx_evt = 4'b0001; cycle();
      chk("R2 rx bit0 -> flag2", flags, 10'b00_0000_0111);
      err_evt = 4'b1000; cycle();
      chk("R2 err bit3 -> flag9", flags[9], 1'b1);
      chk("R7 disabled requests low", {irq_err, irq_rx, irq_tx}, 3'b000);

      // R6: clear strobes at tx positions ignored
      flag_clr = 10'b00_0000_0011; cycle();
      chk("R6 tx flags kept", flags[1:0], 2'b11);

      // R5: event and clear together leaves flag set
      rx_evt = 4'b0100; flag_clr = 10'b00_0001_0000; cycle();
      chk("R5 set beats clear", flags[4], 1'b1);
      flag_clr = 10'b11_1111_1100; cycle();
      chk("R5 clear all", flags[9:2], 8'h00);

      // R9: level request held
      flag_en = 10'b00_0000_0001;
      for (int k = 0; k < 5; k++) begin
         cycle();
         chk("R9 tx request level", irq_tx, 1'b1);
      end

      // R10: data write cancels the completion wait
      tx_data_wr = 1; cycle();
      chk("R3 write clears room", flags[0], 1'b0);
      tx_shift_done = 1; cycle();
      tx_data_wr = 1; cycle();
      bit_tick = 1; cycle();
      chk("R10 cancelled wait", flags[1], 1'b0);
      tx_shift_done = 1; cycle();
      cycle();
      bit_tick = 1; cycle();
      chk("R4 done after tick", flags[1], 1'b1);

      // R3: room event and write in the same cycle
      tx_room_evt = 1; tx_data_wr = 1; cycle();
      chk("R3 room set wins", flags[0], 1'b1);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         tx_room_evt   = ($urandom % 6) == 0;
         tx_data_wr    = ($urandom % 7) == 0;
         tx_shift_done = ($urandom % 8) == 0;
         bit_tick      = ($urandom % 3) == 0;
         for (int b = 0; b < 4; b++) begin
            rx_evt[b]  = ($urandom % 9) == 0;
            err_evt[b] = ($urandom % 11) == 0;
         end
         for (int b = 0; b < 10; b++) flag_clr[b] = ($urandom % 4) == 0;
         if (($urandom % 16) == 0) flag_en = 10'($urandom);
         cycle();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule